// File: doc/BRIEF.md
# Segmented Current-Switch Thermometer Decoder

This block is the synchronous digital front end of a segmented current-steering converter. Each clock edge with the valid strobe high captures a 14-bit code. The code is split into three fields. The top 5 bits select how many of 31 equal coarse current cells are on. The next 4 bits select how many of 15 equal fine cells are on. The bottom 5 bits drive binary-weighted cells directly.

The decoded controls land in a second register, so all 51 switch lines leave the block together on one clock edge. The valid strobe advances both registers. While it is low the whole pipeline freezes and the switches keep their last setting. A synchronous reset clears both registers, which turns every switch off; this matches code 0.

Top module: `segdac_switch_decoder`

## Requirements
- R1: A code present on a rising edge with `code_valid` high and `rst` low is captured. It appears decoded on `sw_ctrl` after the second such edge, so with the strobe held high the latency is two clock cycles.
- R2: The coarse field `code_in[13:9]` (value H) drives `sw_ctrl[50:20]`. Line k, counted from 0 at bit 20, is 1 exactly when H > k, and each line is worth 512 LSB. H = 0 drives no lines and H = 31 drives all 31.
- R3: The fine field `code_in[8:5]` (value M) drives `sw_ctrl[19:5]`. Line k, counted from 0 at bit 5, is 1 exactly when M > k, and each line is worth 32 LSB.
- R4: The low field `code_in[4:0]` appears unchanged on `sw_ctrl[4:0]` as binary-weighted controls, with bit 0 worth 1 LSB.
- R5: For every code from 0 to 16383, the output taken two valid edges after capture satisfies: (count of ones in `sw_ctrl[50:20]`)·512 + (count of ones in `sw_ctrl[19:5]`)·32 + `sw_ctrl[4:0]` = the code. All 51 lines are registered together.
- R6: A rising edge with `rst` high clears both registers. `sw_ctrl` is then all zero, and the first valid edge after reset also gives all zero, because the capture register was cleared too.
- R7: On an edge with `code_valid` low, neither register changes. `code_in` is ignored, `sw_ctrl` holds its value, and the code captured before the pause is still the next one to come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 14 | Input code, unsigned binary |
| code_valid | input | 1 | Advances the two-register pipeline when high |
| sw_ctrl | output | 51 | Switch enables: [50:20] coarse, [19:5] fine, [4:0] binary |

## Verification
The exhaustive sweep streams every code from 0 to 16383 back to back with the strobe high. It compares each output word bit for bit against an expected word built from the field values, and also checks the weighted sum. This separates faults in either decoder's boundary (off-by-one on "greater than k") from faults in field slicing or bit order. A short table of hand-picked codes tests the segment edges: 0, full scale, 511/512-type carries between fields, and fine-only and binary-only values. Directed runs stall the strobe with a changing input to show the pipeline freezes without loss. They also assert reset mid-stream to show that both stages, not just the output, are cleared.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    // Default segmentation of the converter code
    localparam int DEF_CODE_W = 14;
    localparam int DEF_HI_W   = 5;
    localparam int DEF_MID_W  = 4;
endpackage

// File: rtl/segdac_therm.sv
// Binary-to-thermometer decoder: line k is set when the value exceeds k.
module segdac_therm #(
    parameter int IN_W = 4,
    localparam int OUT_N = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  bin_in,
    output logic [OUT_N-1:0] therm_out
);
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign therm_out[k] = ({1'b0, bin_in} > (IN_W+1)'(k));
    end
endmodule

// File: rtl/segdac_stage.sv
// One pipeline register with synchronous clear and enable.
module segdac_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder
    import segdac_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int HI_W   = DEF_HI_W,
    parameter int MID_W  = DEF_MID_W,
    localparam int LO_W  = CODE_W - HI_W - MID_W,
    localparam int HI_N  = (1 << HI_W) - 1,
    localparam int MID_N = (1 << MID_W) - 1,
    localparam int SW_W  = HI_N + MID_N + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_valid,
    output logic [SW_W-1:0]   sw_ctrl
);
    logic [CODE_W-1:0] code_q;
    logic [HI_N-1:0]   hi_lines;
    logic [MID_N-1:0]  mid_lines;
    logic [SW_W-1:0]   sw_next;

    // Stage 1: code capture
    segdac_stage #(.W(CODE_W)) u_capture (
        .clk (clk),
        .rst (rst),
        .en  (code_valid),
        .d   (code_in),
        .q   (code_q)
    );

    // Coarse and fine thermometer decoders
    segdac_therm #(.IN_W(HI_W)) u_hi_dec (
        .bin_in    (code_q[CODE_W-1 -: HI_W]),
        .therm_out (hi_lines)
    );

    segdac_therm #(.IN_W(MID_W)) u_mid_dec (
        .bin_in    (code_q[LO_W +: MID_W]),
        .therm_out (mid_lines)
    );

    assign sw_next = {hi_lines, mid_lines, code_q[LO_W-1:0]};

    // Stage 2: aligned switch-control launch
    segdac_stage #(.W(SW_W)) u_launch (
        .clk (clk),
        .rst (rst),
        .en  (code_valid),
        .d   (sw_next),
        .q   (sw_ctrl)
    );
endmodule

// File: rtl/segdac_switch_decoder_chk.sv
module segdac_switch_decoder_chk #(
    parameter int CODE_W = 14,
    parameter int HI_W   = 5,
    parameter int MID_W  = 4,
    localparam int LO_W  = CODE_W - HI_W - MID_W,
    localparam int HI_N  = (1 << HI_W) - 1,
    localparam int MID_N = (1 << MID_W) - 1,
    localparam int SW_W  = HI_N + MID_N + LO_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_in,
    input logic              code_valid,
    input logic [SW_W-1:0]   sw_ctrl
);
    logic [HI_N:0]  hi_ext;
    logic [MID_N:0] mid_ext;
    int             wsum;

    assign hi_ext  = {1'b0, sw_ctrl[SW_W-1 -: HI_N]};
    assign mid_ext = {1'b0, sw_ctrl[LO_W +: MID_N]};

    always_comb begin
        wsum = $countones(sw_ctrl[SW_W-1 -: HI_N]) * (1 << (CODE_W - HI_W))
             + $countones(sw_ctrl[LO_W +: MID_N]) * (1 << LO_W)
             + int'(sw_ctrl[LO_W-1:0]);
    end

    // R2: coarse lines form a contiguous run from line 0
    p_hi_therm_r2: assert property (@(posedge clk) disable iff (rst)
        ((hi_ext + (HI_N+1)'(1)) & hi_ext) == '0);

    // R3: fine lines form a contiguous run from line 0
    p_mid_therm_r3: assert property (@(posedge clk) disable iff (rst)
        ((mid_ext + (MID_N+1)'(1)) & mid_ext) == '0);

    // R5 / R1: weighted sum equals the code two valid edges earlier
    p_weight_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(code_valid) && !$past(rst))
        |=> (wsum == int'($past(code_in, 2))));

    // R6: reset clears the output register
    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> (sw_ctrl == '0));

    // R6: capture register also cleared, so first valid edge after reset gives zero
    p_reset_first_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && code_valid) |=> (sw_ctrl == '0));

    // R7: strobe low freezes the output
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !code_valid |=> $stable(sw_ctrl));
endmodule

bind segdac_switch_decoder segdac_switch_decoder_chk #(
    .CODE_W (CODE_W),
    .HI_W   (HI_W),
    .MID_W  (MID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_in    (code_in),
    .code_valid (code_valid),
    .sw_ctrl    (sw_ctrl)
);

// File: tb/segdac_switch_decoder_test.sv
`timescale 1ns/1ps
module segdac_switch_decoder_test;
    localparam int NCODE = 16384;
    localparam int NV    = 10;

    // Table entries: {code[13:0], coarse count[4:0], fine count[3:0], low[4:0]}
    localparam logic [27:0] VEC [NV] = '{
        {14'd0,     5'd0,  4'd0,  5'd0},
        {14'd16383, 5'd31, 4'd15, 5'd31},
        {14'd512,   5'd1,  4'd0,  5'd0},
        {14'd511,   5'd0,  4'd15, 5'd31},
        {14'd32,    5'd0,  4'd1,  5'd0},
        {14'd31,    5'd0,  4'd0,  5'd31},
        {14'd8191,  5'd15, 4'd15, 5'd31},
        {14'd8192,  5'd16, 4'd0,  5'd0},
        {14'd5000,  5'd9,  4'd12, 5'd8},
        {14'd1000,  5'd1,  4'd15, 5'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] code_in = '0;
    logic        code_valid = 1'b0;
    logic [50:0] sw_ctrl;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    segdac_switch_decoder uut (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .code_valid (code_valid),
        .sw_ctrl    (sw_ctrl)
    );

    function automatic logic [50:0] bus_of(int nh, int nm, int lo);
        logic [50:0] b = '0;
        for (int k = 0; k < 31; k++) b[20+k] = (k < nh);
        for (int k = 0; k < 15; k++) b[5+k]  = (k < nm);
        b[4:0] = lo[4:0];
        return b;
    endfunction

    function automatic logic [50:0] bus_of_code(int c);
        return bus_of(c / 512, (c / 32) % 16, c % 32);
    endfunction

    function automatic int weight_of(logic [50:0] b);
        return $countones(b[50:20]) * 512 + $countones(b[19:5]) * 32 + int'(b[4:0]);
    endfunction

    task automatic chk(string req, logic [50:0] act, logic [50:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [13:0] c);
        code_valid = v;
        code_in    = c;
    endtask

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk("R6 reset state", sw_ctrl, '0);
        rst = 1'b0;

        // Table walk (R2 R3 R4 R1)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                chk("R2/R3/R4 table", sw_ctrl,
                    bus_of(int'(VEC[i-2][13:9]), int'(VEC[i-2][8:5]), int'(VEC[i-2][4:0])));
            if (i < NV) drive(1'b1, VEC[i][27:14]);
            else        drive(1'b1, 14'd0);
        end

        // R5: exhaustive sweep
        for (int i = 0; i < NCODE + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                checks++;
                if (sw_ctrl !== bus_of_code(i-2) || weight_of(sw_ctrl) != i-2) begin
                    errors++;
                    $display("FAIL R5 code %0d: actual=%h (sum %0d) expected=%h",
                             i-2, sw_ctrl, weight_of(sw_ctrl), bus_of_code(i-2));
                end
            end
            drive(1'b1, 14'((i < NCODE) ? i : 0));
        end

        // R7: hold while strobe low
        @(negedge clk); drive(1'b1, 14'd777);
        @(negedge clk); drive(1'b1, 14'd12345);
        @(negedge clk);
        chk("R1 latency before hold", sw_ctrl, bus_of_code(777));
        drive(1'b0, 14'd4242);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R7 output held", sw_ctrl, bus_of_code(777));
            code_in = 14'(100 + j);
        end
        drive(1'b1, 14'd64);
        @(negedge clk);
        chk("R7 pipeline kept captured code", sw_ctrl, bus_of_code(12345));
        drive(1'b1, 14'd3);
        @(negedge clk);
        chk("R7 stalled input ignored", sw_ctrl, bus_of_code(64));

        // R6: reset mid-stream clears both stages
        drive(1'b1, 14'd9999);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 14'd16000);
        @(negedge clk);
        chk("R6 reset clears output", sw_ctrl, '0);
        rst = 1'b0;
        drive(1'b1, 14'd2049);
        @(negedge clk);
        chk("R6 capture stage cleared", sw_ctrl, '0);
        drive(1'b1, 14'd0);
        @(negedge clk);
        chk("R1 first code after reset", sw_ctrl, bus_of_code(2049));
        chk_int("R5 weight after reset", weight_of(sw_ctrl), 2049);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule